// File: doc/BRIEF.md
# Tile-Mapped Pixel Generator

This block turns a raster scan position into a 3-bit colour without a per-pixel frame buffer. The 640x480 visible area is cut into square 8x8-pixel tiles, giving a grid of 80 columns by 60 rows. Each grid cell holds a 5-bit tile code. The code picks one of 32 monochrome 8x8 patterns, and the pattern bit under the current pixel selects either a foreground or a background colour. The storage is 4800 five-bit codes plus 32 patterns of 64 bits, far below a bit-mapped screen.

A separate timing generator supplies the scan coordinates, a video-enable flag, the two sync levels and a pixel-tick enable. The block reads the tile code and then the pattern row in two registered steps. It delays the enable, the syncs and the in-tile column by the same two ticks, so the colour and the syncs leave together. A host writes tile codes through a simple strobe port and loads the two colours at any time.

Top module: `tile_pixel_gen`

## Requirements
- R1: After reset, rgb_out, hsync_out and vsync_out are 0, the foreground colour is 3'b111 and the background colour is 3'b001, and every tile code is 0, so any enabled pixel shows 3'b001 until the host writes.
- R2: Inputs sampled at a clock edge where pix_tick is 1 reach rgb_out, hsync_out and vsync_out just after the next clock edge where pix_tick is 1.
- R3: The pixel at (scan_x, scan_y) uses the tile at address (scan_y>>3)*80 + (scan_x>>3), in-tile row scan_y[2:0] and in-tile column scan_x[2:0]; the bottom-right pixel (639,479) maps to tile 4799.
- R4: The built-in pattern for code 0 is all clear, for code 31 all set, and for codes 1 to 30 the row word of in-tile row r is the 8-bit value code*8 + r; in-tile column k takes bit 7-k of the row word, so column 0 is the most significant bit.
- R5: A set pattern bit gives the foreground colour and a clear bit the background colour; a clock with color_we at 1 loads fg_in and bg_in, which apply from the next clock on. Colours are ordered red, green, blue from bit 2 down to bit 0.
- R6: A pixel sampled with vid_en_in at 0 gives rgb_out 3'b000 whatever its tile holds.
- R7: On clocks where pix_tick is 0 the pipeline holds: inputs changing then do not reach the outputs.
- R8: A clock with host_we at 1 and host_addr below 4800 stores host_code at that tile; a write with host_addr of 4800 or above changes no tile.
- R9: hsync_out and vsync_out carry hsync_in and vsync_in with the same latency as the colour (R2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_tick | input | 1 | Pixel-rate enable; the pipeline moves only when it is 1 |
| scan_x | input | 10 | Horizontal scan coordinate |
| scan_y | input | 10 | Vertical scan coordinate |
| vid_en_in | input | 1 | Visible-area flag from the timing generator |
| hsync_in | input | 1 | Horizontal sync level from the timing generator |
| vsync_in | input | 1 | Vertical sync level from the timing generator |
| host_we | input | 1 | Tile-code write strobe |
| host_addr | input | 13 | Tile address of the write |
| host_code | input | 5 | Tile code to store |
| color_we | input | 1 | Loads both colour registers |
| fg_in | input | 3 | Foreground colour to load |
| bg_in | input | 3 | Background colour to load |
| rgb_out | output | 3 | Pixel colour, red in bit 2 |
| hsync_out | output | 1 | Horizontal sync aligned with rgb_out |
| vsync_out | output | 1 | Vertical sync aligned with rgb_out |

## Verification
A wrong tile address or a corrupted code shows as a whole 8x8 square in the wrong colour, visible on the first pixel sampled inside that square two ticks later. A wrong pattern bit or column order shows as single pixels flipped between foreground and background within one tile row, and a broken tick gate shows as a value from a non-tick clock appearing at the outputs one tick early. A write that slips past the address bound shows as a tile that should still hold code 0 turning to the written pattern.

// File: rtl/tile_pkg.sv
package tile_pkg;

   // control bits that travel alongside the pixel through the pipeline
   typedef struct packed {
      logic vid_en;
      logic hsync;
      logic vsync;
   } scan_ctl_t;

   localparam int unsigned SCAN_CTL_W = $bits(scan_ctl_t);

endpackage

// File: rtl/pipe_delay.sv
module pipe_delay #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pipe_delay: WIDTH must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("pipe_delay: STAGES must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (adv) begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tile_code_ram.sv
module tile_code_ram #(
   parameter int unsigned DEPTH          = 4800,
   parameter int unsigned ADDR_W         = 13,
   parameter int unsigned CODE_W         = 5,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CODE_W-1:0] rd_code
);

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("tile_code_ram: ADDR_W too narrow for DEPTH");
   end

   logic [CODE_W-1:0] mem [DEPTH];
   logic              wr_ok;
   logic              rd_ok;

   assign wr_ok = wr_en && (wr_addr < ADDR_W'(DEPTH));
   assign rd_ok = rd_addr < ADDR_W'(DEPTH);

   // storage array: either cleared by reset or left as plain RAM
   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
               mem[i] <= '0;
            end
         end else if (wr_ok) begin
            mem[wr_addr[IDX_W-1:0]] <= wr_code;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (wr_ok) begin
            mem[wr_addr[IDX_W-1:0]] <= wr_code;
         end
      end
   end

   // registered read; out-of-grid addresses read as code 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_code <= '0;
      end else if (rd_en) begin
         rd_code <= rd_ok ? mem[rd_addr[IDX_W-1:0]] : '0;
      end
   end

endmodule

// File: rtl/tile_pattern_rom.sv
module tile_pattern_rom #(
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned TILE_LOG2 = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [CODE_W-1:0]        code,
   input  logic [TILE_LOG2-1:0]     row,
   output logic [(1<<TILE_LOG2)-1:0] word
);

   localparam int unsigned TILE_PIX = 1 << TILE_LOG2;
   localparam int unsigned CAT_W    = CODE_W + TILE_LOG2 + TILE_PIX;
   localparam int unsigned N_ENTRY  = (1 << CODE_W) * TILE_PIX;

   if (N_ENTRY > 4096) begin : g_too_big
      $error("tile_pattern_rom: pattern table too large");
   end

   // lowest code is the blank tile, highest code is the solid tile,
   // the others are built from their own code and row number
   function automatic logic [TILE_PIX-1:0] pattern_word(
      input logic [CODE_W-1:0]    c,
      input logic [TILE_LOG2-1:0] r
   );
      logic [CAT_W-1:0] cat;
      cat = CAT_W'({c, r});
      if (c == '0) begin
         return '0;
      end else if (c == '1) begin
         return '1;
      end else begin
         return cat[TILE_PIX-1:0];
      end
   endfunction

   logic [TILE_PIX-1:0] table_q [N_ENTRY];

   for (genvar e = 0; e < int'(N_ENTRY); e++) begin : g_entry
      assign table_q[e] = pattern_word(CODE_W'(e / TILE_PIX), TILE_LOG2'(e % TILE_PIX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
      end else if (rd_en) begin
         word <= table_q[{code, row}];
      end
   end

endmodule

// File: rtl/tile_pixel_gen.sv
module tile_pixel_gen #(
   parameter int unsigned COORD_W   = 10,
   parameter int unsigned H_ACTIVE  = 640,
   parameter int unsigned V_ACTIVE  = 480,
   parameter int unsigned TILE_LOG2 = 3,
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned COLOR_W   = 3,
   parameter logic [COLOR_W-1:0] FG_RESET = 3'b111,
   parameter logic [COLOR_W-1:0] BG_RESET = 3'b001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_tick,
   input  logic [COORD_W-1:0] scan_x,
   input  logic [COORD_W-1:0] scan_y,
   input  logic               vid_en_in,
   input  logic               hsync_in,
   input  logic               vsync_in,
   input  logic               host_we,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [CODE_W-1:0]  host_code,
   input  logic               color_we,
   input  logic [COLOR_W-1:0] fg_in,
   input  logic [COLOR_W-1:0] bg_in,
   output logic [COLOR_W-1:0] rgb_out,
   output logic               hsync_out,
   output logic               vsync_out
);

   import tile_pkg::*;

   localparam int unsigned TILE_PIX = 1 << TILE_LOG2;
   localparam int unsigned COLS     = H_ACTIVE / TILE_PIX;
   localparam int unsigned ROWS     = V_ACTIVE / TILE_PIX;
   localparam int unsigned DEPTH    = COLS * ROWS;
   localparam int unsigned IDX_W    = COORD_W - TILE_LOG2;
   localparam int unsigned LANE_W   = TILE_LOG2 + SCAN_CTL_W;

   // elaboration-time parameter checks
   if (H_ACTIVE % TILE_PIX != 0 || V_ACTIVE % TILE_PIX != 0) begin : g_bad_tiling
      $error("tile_pixel_gen: active area must be a whole number of tiles");
   end
   if (H_ACTIVE > (1 << COORD_W) || V_ACTIVE > (1 << COORD_W)) begin : g_bad_coord
      $error("tile_pixel_gen: COORD_W too narrow for the active area");
   end
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("tile_pixel_gen: ADDR_W too narrow for the tile grid");
   end
   if (TILE_LOG2 >= COORD_W || CODE_W < 1 || COLOR_W < 1) begin : g_bad_misc
      $error("tile_pixel_gen: inconsistent width parameters");
   end

   // ---------------- stage 0: address mapping ----------------
   logic [IDX_W-1:0]     tile_col;
   logic [IDX_W-1:0]     tile_row;
   logic [TILE_LOG2-1:0] sub_row;
   logic [TILE_LOG2-1:0] sub_col;
   logic                 in_grid;
   logic [ADDR_W-1:0]    rd_addr;

   assign tile_col = scan_x[COORD_W-1:TILE_LOG2];
   assign tile_row = scan_y[COORD_W-1:TILE_LOG2];
   assign sub_row  = scan_y[TILE_LOG2-1:0];
   assign sub_col  = scan_x[TILE_LOG2-1:0];
   assign in_grid  = (tile_col < IDX_W'(COLS)) && (tile_row < IDX_W'(ROWS));

   always_comb begin
      if (in_grid) begin
         rd_addr = ADDR_W'(tile_row) * ADDR_W'(COLS) + ADDR_W'(tile_col);
      end else begin
         rd_addr = ADDR_W'(DEPTH);
      end
   end

   // ---------------- stage 1: tile code read ----------------
   logic [CODE_W-1:0]    tile_code_q;
   logic [TILE_LOG2-1:0] sub_row_d1;

   tile_code_ram #(
      .DEPTH          (DEPTH),
      .ADDR_W         (ADDR_W),
      .CODE_W         (CODE_W),
      .CLEAR_ON_RESET (1'b1)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (host_we),
      .wr_addr (host_addr),
      .wr_code (host_code),
      .rd_en   (pix_tick),
      .rd_addr (rd_addr),
      .rd_code (tile_code_q)
   );

   pipe_delay #(
      .WIDTH  (TILE_LOG2),
      .STAGES (1)
   ) u_dly_row (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (pix_tick),
      .d     (sub_row),
      .q     (sub_row_d1)
   );

   // ---------------- stage 2: pattern row read ----------------
   logic [TILE_PIX-1:0] row_word_q;

   tile_pattern_rom #(
      .CODE_W    (CODE_W),
      .TILE_LOG2 (TILE_LOG2)
   ) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (pix_tick),
      .code  (tile_code_q),
      .row   (sub_row_d1),
      .word  (row_word_q)
   );

   // column and control ride two ticks to meet the pattern row
   scan_ctl_t            ctl_in;
   scan_ctl_t            ctl_d2;
   logic [TILE_LOG2-1:0] sub_col_d2;
   logic [LANE_W-1:0]    lane_in;
   logic [LANE_W-1:0]    lane_d2;

   assign ctl_in.vid_en = vid_en_in;
   assign ctl_in.hsync  = hsync_in;
   assign ctl_in.vsync  = vsync_in;
   assign lane_in       = {sub_col, ctl_in};

   pipe_delay #(
      .WIDTH  (LANE_W),
      .STAGES (2)
   ) u_dly_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (pix_tick),
      .d     (lane_in),
      .q     (lane_d2)
   );

   assign sub_col_d2 = lane_d2[LANE_W-1:SCAN_CTL_W];
   assign ctl_d2     = scan_ctl_t'(lane_d2[SCAN_CTL_W-1:0]);

   // ---------------- colour registers ----------------
   logic [COLOR_W-1:0] fg_q;
   logic [COLOR_W-1:0] bg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fg_q <= FG_RESET;
         bg_q <= BG_RESET;
      end else if (color_we) begin
         fg_q <= fg_in;
         bg_q <= bg_in;
      end
   end

   // ---------------- output colouring ----------------
   // column 0 is the leftmost pixel, held in the top bit of the row word
   logic pat_bit;

   assign pat_bit = row_word_q[~sub_col_d2];

   always_comb begin
      if (!ctl_d2.vid_en) begin
         rgb_out = '0;
      end else if (pat_bit) begin
         rgb_out = fg_q;
      end else begin
         rgb_out = bg_q;
      end
   end

   assign hsync_out = ctl_d2.hsync;
   assign vsync_out = ctl_d2.vsync;

endmodule

// File: rtl/tile_pixel_gen_chk.sv
module tile_pixel_gen_chk #(
   parameter int unsigned ADDR_W  = 13,
   parameter int unsigned CODE_W  = 5,
   parameter int unsigned COLOR_W = 3,
   parameter int unsigned DEPTH   = 4800
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pix_tick,
   input logic               color_we,
   input logic [COLOR_W-1:0] fg_in,
   input logic [COLOR_W-1:0] bg_in,
   input logic [COLOR_W-1:0] rgb_out,
   input logic               hsync_out,
   input logic               vsync_out,
   input logic [COLOR_W-1:0] fg_q,
   input logic [COLOR_W-1:0] bg_q,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [CODE_W-1:0]  tile_code_q
);

   // R1: outputs are quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (rgb_out == '0 && !hsync_out && !vsync_out)
            else $error("outputs not quiet in reset");
      end
   end

   // R7: without a tick and without a colour load, nothing at the outputs moves
   assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_tick && !color_we) |=> ($stable(rgb_out) && $stable(hsync_out) && $stable(vsync_out)));

   // R5: output is always black, foreground or background
   assert_palette_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rgb_out == '0) || (rgb_out == fg_q) || (rgb_out == bg_q));

   // R5: a colour load takes both values on the next clock
   assert_colour_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      color_we |=> (fg_q == $past(fg_in) && bg_q == $past(bg_in)));

   // R3: a position outside the grid reads as code 0
   assert_outside_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_tick && rd_addr >= ADDR_W'(DEPTH)) |=> (tile_code_q == '0));

endmodule

bind tile_pixel_gen tile_pixel_gen_chk #(
   .ADDR_W  (ADDR_W),
   .CODE_W  (CODE_W),
   .COLOR_W (COLOR_W),
   .DEPTH   (DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pix_tick    (pix_tick),
   .color_we    (color_we),
   .fg_in       (fg_in),
   .bg_in       (bg_in),
   .rgb_out     (rgb_out),
   .hsync_out   (hsync_out),
   .vsync_out   (vsync_out),
   .fg_q        (fg_q),
   .bg_q        (bg_q),
   .rd_addr     (rd_addr),
   .tile_code_q (tile_code_q)
);

// File: tb/tb_tile_pixel_gen.sv
module tb_tile_pixel_gen;

   localparam int NTILE = 4800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_tick = 1'b0;
   logic [9:0]  scan_x = '0;
   logic [9:0]  scan_y = '0;
   logic        vid_en_in = 1'b0;
   logic        hsync_in = 1'b0;
   logic        vsync_in = 1'b0;
   logic        host_we = 1'b0;
   logic [12:0] host_addr = '0;
   logic [4:0]  host_code = '0;
   logic        color_we = 1'b0;
   logic [2:0]  fg_in = '0;
   logic [2:0]  bg_in = '0;
   logic [2:0]  rgb_out;
   logic        hsync_out;
   logic        vsync_out;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [4:0]  shadow [NTILE];
   logic [2:0]  fg_exp = 3'b111;
   logic [2:0]  bg_exp = 3'b001;
   int          wr_list [200];

   always #10 clk = ~clk;

   tile_pixel_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_tick  (pix_tick),
      .scan_x    (scan_x),
      .scan_y    (scan_y),
      .vid_en_in (vid_en_in),
      .hsync_in  (hsync_in),
      .vsync_in  (vsync_in),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_code (host_code),
      .color_we  (color_we),
      .fg_in     (fg_in),
      .bg_in     (bg_in),
      .rgb_out   (rgb_out),
      .hsync_out (hsync_out),
      .vsync_out (vsync_out)
   );

   // expected pattern row word from R4
   function automatic logic [7:0] exp_word(input logic [4:0] c, input logic [2:0] r);
      if (c == 5'd0) return 8'h00;
      if (c == 5'd31) return 8'hFF;
      return 8'(int'(c) * 8 + int'(r));
   endfunction

   // expected colour from R3, R4, R5, R6
   function automatic logic [2:0] exp_rgb(input int x, input int y, input logic en);
      int t;
      logic [7:0] w;
      if (!en) return 3'b000;
      t = (y / 8) * 80 + (x / 8);
      w = exp_word(shadow[t], 3'(y % 8));
      return w[7 - (x % 8)] ? fg_exp : bg_exp;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic host_write(input int a, input logic [4:0] c);
      host_we = 1'b1;
      host_addr = 13'(a);
      host_code = c;
      @(negedge clk);
      host_we = 1'b0;
      if (a < NTILE) shadow[a] = c;
   endtask

   task automatic load_colours(input logic [2:0] f, input logic [2:0] b);
      color_we = 1'b1;
      fg_in = f;
      bg_in = b;
      @(negedge clk);
      color_we = 1'b0;
      fg_exp = f;
      bg_exp = b;
   endtask

   // R2, R7, R9: present one pixel, scramble inputs on a non-tick clock and
   // on the following tick, then read the result after that second tick
   task automatic pixel(input int x, input int y, input logic en,
                        input logic hs, input logic vs, input string tag);
      scan_x = 10'(x);
      scan_y = 10'(y);
      vid_en_in = en;
      hsync_in = hs;
      vsync_in = vs;
      pix_tick = 1'b1;
      @(negedge clk);
      pix_tick = 1'b0;
      scan_x = 10'($urandom_range(639, 0));
      scan_y = 10'($urandom_range(479, 0));
      vid_en_in = ~en;
      hsync_in = ~hs;
      vsync_in = ~vs;
      @(negedge clk);
      pix_tick = 1'b1;
      @(negedge clk);
      pix_tick = 1'b0;
      check({tag, " rgb"}, int'(rgb_out), int'(exp_rgb(x, y, en)));
      check({tag, " R9 hsync"}, int'(hsync_out), int'(hs));
      check({tag, " R9 vsync"}, int'(vsync_out), int'(vs));
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      void'($urandom(32'd7741));
      for (int i = 0; i < NTILE; i++) shadow[i] = 5'd0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 rgb after reset", int'(rgb_out), 0);
      check("R1 hsync after reset", int'(hsync_out), 0);
      check("R1 vsync after reset", int'(vsync_out), 0);
      pixel(100, 200, 1'b1, 1'b0, 1'b0, "R1 blank screen bg");
      pixel(639, 479, 1'b1, 1'b1, 1'b0, "R1 blank corner bg");

      // R4: solid tile and column order of a patterned tile
      host_write(0, 5'd31);
      pixel(0, 0, 1'b1, 1'b0, 1'b1, "R4 solid col0");
      pixel(7, 5, 1'b1, 1'b1, 1'b1, "R4 solid col7");
      host_write(1, 5'd1);
      pixel(12, 0, 1'b1, 1'b0, 1'b0, "R4 code1 row0 col4 set");
      pixel(11, 0, 1'b1, 1'b0, 1'b0, "R4 code1 row0 col3 clear");
      pixel(8, 7, 1'b1, 1'b0, 1'b0, "R4 code1 row7 col0 clear");
      pixel(15, 7, 1'b1, 1'b0, 1'b0, "R4 code1 row7 col7 set");
      host_write(2, 5'd30);
      pixel(16, 3, 1'b1, 1'b0, 1'b0, "R4 code30 row3 col0 MSB");

      // R3: last tile and its neighbours
      host_write(4799, 5'd31);
      pixel(639, 479, 1'b1, 1'b0, 1'b0, "R3 tile 4799 corner");
      pixel(632, 472, 1'b1, 1'b0, 1'b0, "R3 tile 4799 origin");
      pixel(631, 479, 1'b1, 1'b0, 1'b0, "R3 tile 4798 untouched");
      pixel(639, 471, 1'b1, 1'b0, 1'b0, "R3 tile 4719 untouched");

      // R6: blanking over a solid tile
      pixel(3, 3, 1'b0, 1'b1, 1'b0, "R6 blank over solid");
      pixel(636, 476, 1'b0, 1'b0, 1'b1, "R6 blank over corner");

      // R8: writes at or above the grid size are dropped
      host_write(4800, 5'd31);
      host_write(6000, 5'd31);
      host_write(8191, 5'd31);
      pixel(0, 120, 1'b1, 1'b0, 1'b0, "R8 tile 1200 after oob write");
      pixel(8 * (3391 % 80), 8 * (3391 / 80), 1'b1, 1'b0, 1'b0, "R8 tile 3391 after oob write");
      pixel(631, 472, 1'b1, 1'b0, 1'b0, "R8 tile 4798 after oob write");
      pixel(0, 0, 1'b1, 1'b0, 1'b0, "R8 tile 0 kept");

      // R5: new colours
      load_colours(3'b110, 3'b010);
      pixel(2, 2, 1'b1, 1'b0, 1'b0, "R5 fg yellow");
      pixel(300, 300, 1'b1, 1'b0, 1'b0, "R5 bg green");

      // random tile writes then random pixels (R2, R3, R4, R7, R8)
      for (int i = 0; i < 200; i++) begin
         int a;
         a = int'($urandom_range(NTILE - 1, 0));
         wr_list[i] = a;
         host_write(a, 5'($urandom_range(31, 0)));
      end
      for (int i = 0; i < 300; i++) begin
         int x;
         int y;
         logic en;
         if (i % 2 == 0) begin
            int t;
            t = wr_list[$urandom_range(199, 0)];
            x = (t % 80) * 8 + int'($urandom_range(7, 0));
            y = (t / 80) * 8 + int'($urandom_range(7, 0));
         end else begin
            x = int'($urandom_range(639, 0));
            y = int'($urandom_range(479, 0));
         end
         en = ($urandom_range(7, 0) != 0);
         if (i == 150) load_colours(3'b101, 3'b000);
         pixel(x, y, en, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), "R2 R7 random pixel");
      end

      summary();
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         summary();
         $finish;
      end
   end

endmodule